// File: doc/BRIEF.md
# Non-Power-of-Two Mirror Folder

This block maps a linear offset onto a memory whose size need not be a power of two. It reproduces the folding pattern of a partially decoded address bus. The offset is cut down by repeatedly stripping its highest set bit. At the same time, the size is carved into power-of-two chunks. Each chunk the size can still afford is added to a running base. A chunk the size cannot afford is simply dropped from the offset. A size of a power of two therefore gives a plain low-bit mask. A size such as 3·2^k gives the familiar "last chunk repeats" mirror.

The block is sequential and examines one bit position per clock. It starts from the top bit of the address space and works downward. It stops as soon as the working offset falls below the working size. A caller presents `addr` and `size` together with a one-cycle `start` while the block is idle. It then waits for the single-cycle `done` pulse and reads `result`, which holds its value until the next accepted start.

Top module: `mirror_fold`

## Requirements
- R1: When `size` is zero, `result` is zero whatever `addr` is.
- R2: For any nonzero `size`, `result` equals the output of this loop. Set base to 0, set the mask to bit ADDR_W-1, and set the working offset and size from the inputs. While the offset is at least the size: move the mask down to the highest set offset bit and subtract that bit from the offset. If the working size exceeds the mask, subtract the mask from the size and add it to the base. Then shift the mask down one more bit. When the loop ends, the result is base plus offset.
- R3: When `size` is 2^k (0 ≤ k ≤ ADDR_W), `result` equals `addr` with every bit at position k and above cleared.
- R4: When `addr` is below `size`, `result` equals `addr`.
- R5: `done` rises no later than ADDR_W+1 rising clock edges after the edge that accepts `start`.
- R6: `done` is high for exactly one cycle, and `busy` is low from then on. `result` keeps its value until the next accepted start.
- R7: A `start` that arrives while `busy` is high is ignored. The pending operation completes with its original operands.
- R8: A synchronous active-high `rst` drives `busy`, `done` and `result` to zero at the next edge, including in the middle of an operation.
- R9: For a nonzero `size`, `result` is strictly less than `size`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled only while idle) |
| addr | input | ADDR_W (24) | Linear offset to fold |
| size | input | ADDR_W+1 (25) | Memory size in bytes, 0 to 2^ADDR_W |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | ADDR_W (24) | Folded offset, held until the next start |

## Verification
A wrong internal state can take several forms here. The scan index can slip, a chunk can be credited to the base when the size cannot afford it, or the stop test can compare the wrong operands. Each of these corrupts `result` on the very `done` pulse of the affected operation. That is at most ADDR_W+1 cycles after `start`. Comparing every result against an independent model of the loop exposes such faults within one operation. This holds over random sizes and over mixed power-of-two and 3·2^k sizes. A sequencing fault shows at the ports instead: a stuck `busy`, a repeated `done`, or a start accepted mid-flight. These show up as a latency over bound, a second pulse, or a result computed from the wrong operands.

// File: rtl/mirror_fold_pkg.sv
package mirror_fold_pkg;
   typedef enum logic [0:0] {
      FOLD_IDLE = 1'b0,
      FOLD_RUN  = 1'b1
   } fold_state_e;
endpackage

// File: rtl/mirror_fold_step.sv
// One bit position of the fold: strip the scanned bit if set, and credit
// the chunk to the base when the remaining size can still hold it.
module mirror_fold_step #(
   parameter int ADDR_W = 24,
   parameter int IDX_W  = 5
) (
   input  logic [ADDR_W-1:0] addr_w,
   input  logic [ADDR_W:0]   size_w,
   input  logic [ADDR_W-1:0] base_w,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr_n,
   output logic [ADDR_W:0]   size_n,
   output logic [ADDR_W-1:0] base_n,
   output logic              fits
);
   logic [ADDR_W-1:0] mask;
   logic              hit;

   for (genvar g = 0; g < ADDR_W; g++) begin : g_dec
      assign mask[g] = (idx == IDX_W'(g));
   end

   assign hit  = |(addr_w & mask);
   assign fits = ({1'b0, addr_w} < size_w);

   always_comb begin
      addr_n = addr_w;
      size_n = size_w;
      base_n = base_w;
      if (hit) begin
         addr_n = addr_w - mask;
         if (size_w > {1'b0, mask}) begin
            size_n = size_w - {1'b0, mask};
            base_n = base_w + mask;
         end
      end
   end
endmodule

// File: rtl/mirror_fold_fsm.sv
module mirror_fold_fsm
   import mirror_fold_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic fits,
   input  logic zero_size,
   output logic load,
   output logic step_en,
   output logic finish,
   output logic busy,
   output logic done
);
   fold_state_e state_q;

   assign busy    = (state_q == FOLD_RUN);
   assign load    = (state_q == FOLD_IDLE) && start;
   assign finish  = busy && (fits || zero_size);
   assign step_en = busy && !finish;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FOLD_IDLE;
         done    <= 1'b0;
      end else begin
         done <= finish;
         if (load)        state_q <= FOLD_RUN;
         else if (finish) state_q <= FOLD_IDLE;
      end
   end

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

// File: rtl/mirror_fold.sv
module mirror_fold #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W:0]   size,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] result
);
   localparam int IDX_W = $clog2(ADDR_W);
   localparam int LAT_W = $clog2(ADDR_W + 3);
   localparam int MAX_BUSY = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_width
      $error("mirror_fold: ADDR_W must be in 2..30");
   end

   logic [ADDR_W-1:0] addr_w, addr_n, base_w, base_n;
   logic [ADDR_W:0]   size_w, size_n, size_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LAT_W-1:0]  lat_q;
   logic              fits, load, step_en, finish;

   mirror_fold_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
      .addr_w (addr_w),
      .size_w (size_w),
      .base_w (base_w),
      .idx    (idx_q),
      .addr_n (addr_n),
      .size_n (size_n),
      .base_n (base_n),
      .fits   (fits)
   );

   mirror_fold_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .fits      (fits),
      .zero_size (size_w == '0),
      .load      (load),
      .step_en   (step_en),
      .finish    (finish),
      .busy      (busy),
      .done      (done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_w <= '0;
         size_w <= '0;
         base_w <= '0;
         size_q <= '0;
         idx_q  <= '0;
         result <= '0;
      end else if (load) begin
         addr_w <= addr;
         size_w <= size;
         size_q <= size;
         base_w <= '0;
         idx_q  <= IDX_W'(ADDR_W - 1);
      end else if (step_en) begin
         addr_w <= addr_n;
         size_w <= size_n;
         base_w <= base_n;
         idx_q  <= idx_q - 1'b1;
      end else if (finish) begin
         result <= (size_w == '0) ? '0 : (base_w + addr_w);
      end
   end

   // cycle counter used only by the latency check below
   always_ff @(posedge clk) begin
      if (rst || load) lat_q <= '0;
      else if (busy)   lat_q <= lat_q + 1'b1;
   end

   p_latency_r5: assert property (@(posedge clk) disable iff (rst)
      busy |-> (lat_q < LAT_W'(MAX_BUSY)));
   p_zero_size_r1: assert property (@(posedge clk) disable iff (rst)
      (done && size_q == '0) |-> (result == '0));
   p_in_range_r9: assert property (@(posedge clk) disable iff (rst)
      (done && size_q != '0) |-> ({1'b0, result} < size_q));
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(result));
   p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(size_q));
endmodule

// File: tb/tb_mirror_fold.sv
module tb_mirror_fold;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [AW:0]   size = '0;
   logic          busy, done;
   logic [AW-1:0] result;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mirror_fold #(.ADDR_W(AW)) dut (
      .clk(clk), .rst(rst), .start(start), .addr(addr), .size(size),
      .busy(busy), .done(done), .result(result)
   );

   function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input logic [AW:0] s);
      logic [AW:0] ad, sz, bs, m;
      if (s == '0) return '0;
      ad = {1'b0, a}; sz = s; bs = '0; m = (AW+1)'(1) << (AW-1);
      while (ad >= sz) begin
         while ((ad & m) == '0) m = m >> 1;
         ad = ad - m;
         if (sz > m) begin sz = sz - m; bs = bs + m; end
         m = m >> 1;
      end
      return AW'(bs + ad);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // runs one operation, returns edge count until done is seen
   task automatic run(input logic [AW-1:0] a, input logic [AW:0] s, output int lat);
      @(negedge clk);
      addr = a; size = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic op(input string req, input logic [AW-1:0] a, input logic [AW:0] s,
                     input logic [AW-1:0] exp);
      int lat;
      run(a, s, lat);
      check(req, {8'h0, result}, {8'h0, exp});
      check("R5 latency", lat, (lat <= AW + 2) ? lat : AW + 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int lat;
      logic [AW-1:0] held;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      check("R8 busy", busy, 0);
      check("R8 done", done, 0);
      check("R8 result", result, 0);

      // R1 zero size
      op("R1 zero size", 24'hABCDEF, 25'h0, 24'h0);
      op("R1 zero size max addr", 24'hFFFFFF, 25'h0, 24'h0);
      // R4 identity below size
      op("R4 below size", 24'h000123, 25'h001000, 24'h000123);
      op("R4 full space", 24'hFFFFFF, 25'h1000000, 24'hFFFFFF);
      // R3 power-of-two sizes
      for (int k = 0; k <= AW; k++) begin
         logic [AW-1:0] a;
         logic [AW:0]   s;
         a = AW'($urandom);
         s = (AW+1)'(1) << k;
         op("R3 pow2 mask", a, s, AW'({1'b0, a} & (s - 1'b1)));
      end
      // R2 directed non-power-of-two corners
      op("R2 3MB top", 24'hFFFFFF, 25'h300000, model(24'hFFFFFF, 25'h300000));
      op("R2 3MB mirror", 24'h300000, 25'h300000, 24'h200000);
      op("R2 size one", 24'h5A5A5A, 25'h1, 24'h0);
      op("R2 size 5", 24'h000007, 25'h5, model(24'h7, 25'h5));
      op("R2 odd size", 24'hFFFFFF, 25'hFFFFFF, model(24'hFFFFFF, 25'hFFFFFF));
      // R2/R9 random
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         logic [AW:0]   s;
         a = AW'($urandom);
         case (i % 4)
            0: s = (AW+1)'($urandom) % 25'h1000001;
            1: s = (AW+1)'(3) << ($urandom % 23);
            2: s = (AW+1)'($urandom % 4096);
            default: s = ((AW+1)'(1) << ($urandom % 24)) + (AW+1)'($urandom % 1024);
         endcase
         run(a, s, lat);
         check("R2 model", result, model(a, s));
         if (s != 0) check("R9 range", ({1'b0, result} < s), 1);
         check("R5 latency", (lat <= AW + 2), 1);
      end

      // R6 one-cycle done, hold of result
      run(24'h123456, 25'h180000, lat);
      held = result;
      @(negedge clk);
      check("R6 done pulse", done, 0);
      check("R6 busy low", busy, 0);
      repeat (5) @(negedge clk);
      check("R6 hold", result, held);

      // R7 start ignored while busy
      @(negedge clk);
      addr = 24'hFFFFFF; size = 25'h300000; start = 1'b1;
      @(negedge clk);
      addr = 24'h000011; size = 25'h000010;
      repeat (3) @(negedge clk);
      start = 1'b0;
      lat = 4;
      while (!done && lat < 100) begin @(negedge clk); lat++; end
      check("R7 ignore start", result, model(24'hFFFFFF, 25'h300000));
      @(negedge clk);
      check("R7 idle after", busy, 0);

      // R8 reset mid-operation
      @(negedge clk);
      addr = 24'hFFFFFF; size = 25'h000003; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R8 mid busy", busy, 0);
      check("R8 mid done", done, 0);
      check("R8 mid result", result, 0);
      rst = 1'b0;
      @(negedge clk);
      op("R8 after reset", 24'h000005, 25'h000003, model(24'h5, 25'h3));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule